// File: doc/BRIEF.md
# Undefined-Opcode NOP Sequencer

This block runs inside an 8-bit processor core, or next to one as a bus model, and handles the opcode bytes that the instruction set leaves undefined. Each such byte executes as a no-operation. Every one has a fixed length in bytes and a fixed duration in bus cycles. The block never changes a register. Its only lasting effect is the program-counter step that it reports when the instruction ends. Any other opcode is flagged as defined in its fetch cycle and left to the main decoder.

The core pulses `opValid` with the opcode byte in each opcode fetch cycle. If the byte is undefined, the sequencer numbers the cycles of the no-operation from 1. It gives the total length, says in each cycle whether that cycle reads memory beyond the opcode fetch, and pulses `nopDone` in the last cycle together with the byte count to add to the program counter. A registered flag tells the interrupt logic to hold off after a one-cycle no-operation. A run of them back to back keeps the hold in place until an instruction of any other kind is fetched.

Top module: `nop_sequencer`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, all outputs are 0: `isDefined`, `nopActive`, `cycIdx`, `nopTotal`, `cycRead`, `nopDone`, `pcStep` and `irqHold`.
- R2: Opcodes with low nibble 3 (all sixteen), and opcodes with low nibble B except CB and DB, are 1-byte, 1-cycle no-operations. They finish in their fetch cycle and make no read after it.
- R3: Opcodes 02, 22, 42, 62, 82, C2 and E2 are 2-byte, 2-cycle no-operations. Cycle 2 is a read.
- R4: Opcode 44 is 2 bytes and 3 cycles, with reads in cycles 2 and 3. Opcodes 54, D4 and F4 are 2 bytes and 4 cycles, with reads in cycles 2 and 4.
- R5: Opcode 5C is 3 bytes and 8 cycles. Opcodes DC and FC are 3 bytes and 4 cycles. For all three, cycles 2, 3 and 4 are reads and every later cycle is not.
- R6: An accepted fetch of any opcode outside R2 to R5, including CB and DB, raises `isDefined` in that cycle only, and `nopActive` stays low.
- R7: During a no-operation, `cycIdx` is 1 in the fetch cycle and rises by one each cycle. `nopTotal` holds the cycle count throughout. `nopDone` is high exactly in the cycle where `cycIdx` equals `nopTotal`. `pcStep` carries the byte length in that cycle and is 0 in every other cycle.
- R8: An `opValid` pulse that arrives while a multi-cycle no-operation is in progress is ignored. The count goes on, `isDefined` stays low, and `irqHold` keeps its value.
- R9: `irqHold` is a register. An accepted fetch of an R2 opcode sets it, and an accepted fetch of any other opcode clears it. In cycles with no accepted fetch it keeps its value.
- R10: `cycRead` is 0 in cycle 1 of every no-operation and in every cycle where `nopActive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Opcode fetch cycle strobe |
| opcode | input | 8 | Opcode byte fetched in this cycle |
| isDefined | output | 1 | Fetched opcode is not an undefined one |
| nopActive | output | 1 | This cycle belongs to a no-operation |
| cycIdx | output | 4 | Cycle number within the no-operation, starting at 1 |
| nopTotal | output | 4 | Total cycles of the current no-operation |
| cycRead | output | 1 | This cycle performs a memory read beyond the opcode fetch |
| nopDone | output | 1 | Last cycle of the no-operation |
| pcStep | output | 2 | Program-counter increment, valid with nopDone |
| irqHold | output | 1 | Interrupt must not be taken at the next boundary |

## Verification
All 256 opcode values are fetched one at a time from idle, and every cycle of each one is followed to completion. This separates the 1-cycle, 2-cycle, 3-cycle, 4-cycle and 8-cycle groups from the defined opcodes, and it catches the CB/DB exclusions and the odd-nibble neighbours of the listed codes. A fetch injected during an 8-cycle no-operation, carrying first a 1-cycle code and then a defined code, shows whether a busy sequencer ignores the strobe. A sequence of back-to-back 1-cycle codes, idle gaps, a defined code and a 2-cycle code shows what sets the interrupt hold, what keeps it and what clears it.

// File: rtl/nopseq_pkg.sv
package nopseq_pkg;
  localparam int OP_W    = 8;
  localparam int MAX_CYC = 8;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int LEN_W   = 2;

  // one row of the undefined-opcode table
  typedef struct packed {
    logic               undef;
    logic [LEN_W-1:0]   len;
    logic [CNT_W-1:0]   cyc;
    logic [MAX_CYC-1:0] rdMask;  // bit k set: cycle k+1 reads memory
  } nopEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fetch;   // opcode fetch accepted this cycle
    logic load;    // capture a multi-cycle entry
    logic step;    // advance the cycle counter
    logic finish;  // last cycle of a multi-cycle entry
  } nopStrobe_t;
endpackage

// File: rtl/nopseq_decode.sv
module nopseq_decode
  import nopseq_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output nopEntry_t       entry
);
  localparam logic [MAX_CYC-1:0] RD_C2     = MAX_CYC'(8'b0000_0010);
  localparam logic [MAX_CYC-1:0] RD_C23    = MAX_CYC'(8'b0000_0110);
  localparam logic [MAX_CYC-1:0] RD_C24    = MAX_CYC'(8'b0000_1010);
  localparam logic [MAX_CYC-1:0] RD_C234   = MAX_CYC'(8'b0000_1110);

  logic [3:0] loNib;
  logic [3:0] hiNib;

  assign loNib = opcode[3:0];
  assign hiNib = opcode[7:4];

  always_comb begin
    entry = '0;
    if (loNib == 4'h3 || (loNib == 4'hB && hiNib != 4'hC && hiNib != 4'hD)) begin
      entry.undef  = 1'b1;
      entry.len    = LEN_W'(1);
      entry.cyc    = CNT_W'(1);
      entry.rdMask = '0;
    end else if (loNib == 4'h2 && !hiNib[0] && hiNib != 4'hA) begin
      entry.undef  = 1'b1;
      entry.len    = LEN_W'(2);
      entry.cyc    = CNT_W'(2);
      entry.rdMask = RD_C2;
    end else begin
      case (opcode)
        8'h44: begin
          entry.undef  = 1'b1;
          entry.len    = LEN_W'(2);
          entry.cyc    = CNT_W'(3);
          entry.rdMask = RD_C23;
        end
        8'h54, 8'hD4, 8'hF4: begin
          entry.undef  = 1'b1;
          entry.len    = LEN_W'(2);
          entry.cyc    = CNT_W'(4);
          entry.rdMask = RD_C24;
        end
        8'h5C: begin
          entry.undef  = 1'b1;
          entry.len    = LEN_W'(3);
          entry.cyc    = CNT_W'(8);
          entry.rdMask = RD_C234;
        end
        8'hDC, 8'hFC: begin
          entry.undef  = 1'b1;
          entry.len    = LEN_W'(3);
          entry.cyc    = CNT_W'(4);
          entry.rdMask = RD_C234;
        end
        default: entry = '0;
      endcase
    end
  end
endmodule

// File: rtl/nopseq_ctrl.sv
module nopseq_ctrl
  import nopseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       curUndef,
  input  logic       curSingle,
  input  logic       lastCyc,
  output nopStrobe_t strb,
  output logic       busy
);
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;
  ctrlState_t stateNext;
  logic       accept;

  assign busy   = (state == ST_RUN);
  assign accept = opValid && (state == ST_IDLE);

  always_comb begin
    strb.fetch  = accept;
    strb.load   = accept && curUndef && !curSingle;
    strb.step   = busy && !lastCyc;
    strb.finish = busy && lastCyc;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strb.load)   stateNext = ST_RUN;
      ST_RUN:  if (strb.finish) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/nopseq_dpath.sv
module nopseq_dpath
  import nopseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  nopStrobe_t       strb,
  input  logic             busy,
  input  nopEntry_t        curEnt,
  output logic             lastCyc,
  output logic             isDefined,
  output logic             nopActive,
  output logic [CNT_W-1:0] cycIdx,
  output logic [CNT_W-1:0] nopTotal,
  output logic             cycRead,
  output logic             nopDone,
  output logic [LEN_W-1:0] pcStep,
  output logic             irqHold
);
  nopEntry_t        latEnt;
  logic [CNT_W-1:0] cnt;
  logic             newNop;
  logic             newSingle;
  logic             latRead;

  assign newNop    = strb.fetch && curEnt.undef;
  assign newSingle = newNop && (curEnt.cyc == CNT_W'(1));
  assign lastCyc   = (cnt == latEnt.cyc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latEnt  <= '0;
      cnt     <= '0;
      irqHold <= 1'b0;
    end else begin
      if (strb.load) begin
        latEnt <= curEnt;
        cnt    <= CNT_W'(2);
      end else if (strb.step) begin
        cnt <= cnt + CNT_W'(1);
      end else if (strb.finish) begin
        cnt <= '0;
      end
      if (strb.fetch) irqHold <= newSingle;
    end
  end

  // pick the read bit for the current cycle number
  always_comb begin
    latRead = 1'b0;
    for (int k = 1; k < MAX_CYC; k++) begin
      if (cnt == CNT_W'(k + 1)) latRead = latEnt.rdMask[k];
    end
  end

  always_comb begin
    isDefined = strb.fetch && !curEnt.undef;
    nopActive = newNop || busy;
    if (busy) begin
      cycIdx   = cnt;
      nopTotal = latEnt.cyc;
      cycRead  = latRead;
      nopDone  = strb.finish;
      pcStep   = strb.finish ? latEnt.len : '0;
    end else if (newNop) begin
      cycIdx   = CNT_W'(1);
      nopTotal = curEnt.cyc;
      cycRead  = 1'b0;
      nopDone  = newSingle;
      pcStep   = newSingle ? curEnt.len : '0;
    end else begin
      cycIdx   = '0;
      nopTotal = '0;
      cycRead  = 1'b0;
      nopDone  = 1'b0;
      pcStep   = '0;
    end
  end
endmodule

// File: rtl/nop_sequencer.sv
module nop_sequencer
  import nopseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opcode,
  output logic             isDefined,
  output logic             nopActive,
  output logic [CNT_W-1:0] cycIdx,
  output logic [CNT_W-1:0] nopTotal,
  output logic             cycRead,
  output logic             nopDone,
  output logic [LEN_W-1:0] pcStep,
  output logic             irqHold
);
  nopEntry_t  curEnt;
  nopStrobe_t strb;
  logic       busy;
  logic       lastCyc;

  nopseq_decode uDecode (
    .opcode (opcode),
    .entry  (curEnt)
  );

  nopseq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .curUndef  (curEnt.undef),
    .curSingle (curEnt.cyc == CNT_W'(1)),
    .lastCyc   (lastCyc),
    .strb      (strb),
    .busy      (busy)
  );

  nopseq_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (busy),
    .curEnt    (curEnt),
    .lastCyc   (lastCyc),
    .isDefined (isDefined),
    .nopActive (nopActive),
    .cycIdx    (cycIdx),
    .nopTotal  (nopTotal),
    .cycRead   (cycRead),
    .nopDone   (nopDone),
    .pcStep    (pcStep),
    .irqHold   (irqHold)
  );
endmodule

// File: rtl/nop_sequencer_chk.sv
module nop_sequencer_chk
  import nopseq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic             isDefined,
  input logic             nopActive,
  input logic [CNT_W-1:0] cycIdx,
  input logic [CNT_W-1:0] nopTotal,
  input logic             cycRead,
  input logic             nopDone,
  input logic [LEN_W-1:0] pcStep,
  input logic             irqHold
);
  a_r7_index_steps: assert property (@(posedge clk) disable iff (!rstN)
    (nopActive && !nopDone) |=> (nopActive && cycIdx == $past(cycIdx) + CNT_W'(1)));

  a_r7_done_at_total: assert property (@(posedge clk) disable iff (!rstN)
    nopDone |-> (nopActive && cycIdx == nopTotal));

  a_r7_step_only_done: assert property (@(posedge clk) disable iff (!rstN)
    !nopDone |-> (pcStep == '0));

  a_r7_total_held: assert property (@(posedge clk) disable iff (!rstN)
    (nopActive && !nopDone) |=> $stable(nopTotal));

  a_r6_defined_idle: assert property (@(posedge clk) disable iff (!rstN)
    isDefined |-> !nopActive);

  a_r10_no_first_read: assert property (@(posedge clk) disable iff (!rstN)
    (!nopActive || cycIdx == CNT_W'(1)) |-> !cycRead);

  a_r2_single_len: assert property (@(posedge clk) disable iff (!rstN)
    (nopActive && nopTotal == CNT_W'(1)) |-> (nopDone && pcStep == LEN_W'(1)));

  a_r8_busy_no_defined: assert property (@(posedge clk) disable iff (!rstN)
    (nopActive && !nopDone) |=> !isDefined);

  a_r9_hold_set: assert property (@(posedge clk) disable iff (!rstN)
    (nopDone && cycIdx == CNT_W'(1)) |=> irqHold);

  a_r9_hold_clear: assert property (@(posedge clk) disable iff (!rstN)
    isDefined |=> !irqHold);

  a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(irqHold));
endmodule

bind nop_sequencer nop_sequencer_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .isDefined (isDefined),
  .nopActive (nopActive),
  .cycIdx    (cycIdx),
  .nopTotal  (nopTotal),
  .cycRead   (cycRead),
  .nopDone   (nopDone),
  .pcStep    (pcStep),
  .irqHold   (irqHold)
);

// File: tb/nop_sequencer_test.sv
module nop_sequencer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [7:0] opcode = 8'hEA;
  logic       isDefined, nopActive, cycRead, nopDone, irqHold;
  logic [3:0] cycIdx, nopTotal;
  logic [1:0] pcStep;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nop_sequencer uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .isDefined(isDefined), .nopActive(nopActive), .cycIdx(cycIdx),
    .nopTotal(nopTotal), .cycRead(cycRead), .nopDone(nopDone),
    .pcStep(pcStep), .irqHold(irqHold)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected table from the requirements, built from nibble arithmetic
  function automatic void model(input int op, output bit undef, output int len,
                                output int cyc, output bit [9:0] rd, output string req);
    int lo = op % 16;
    int hi = op / 16;
    undef = 1'b0; len = 0; cyc = 0; rd = '0; req = "R6";
    if (lo == 3 || (lo == 11 && hi != 12 && hi != 13)) begin
      undef = 1'b1; len = 1; cyc = 1; req = "R2";
    end else if (lo == 2 && hi % 2 == 0 && hi != 10) begin
      undef = 1'b1; len = 2; cyc = 2; rd[2] = 1'b1; req = "R3";
    end else if (op == 68) begin
      undef = 1'b1; len = 2; cyc = 3; rd[2] = 1'b1; rd[3] = 1'b1; req = "R4";
    end else if (lo == 4 && (hi == 5 || hi == 13 || hi == 15)) begin
      undef = 1'b1; len = 2; cyc = 4; rd[2] = 1'b1; rd[4] = 1'b1; req = "R4";
    end else if (lo == 12 && (hi == 5 || hi == 13 || hi == 15)) begin
      undef = 1'b1; len = 3; cyc = (hi == 5) ? 8 : 4;
      rd[2] = 1'b1; rd[3] = 1'b1; rd[4] = 1'b1; req = "R5";
    end
  endfunction

  task automatic idle_check(input string req);
    chk(req, "nopActive idle", nopActive, 0);
    chk(req, "cycIdx idle", cycIdx, 0);
    chk("R10", "cycRead idle", cycRead, 0);
    chk(req, "pcStep idle", pcStep, 0);
  endtask

  task automatic fetch(input logic [7:0] op);
    @(negedge clk);
    opValid = 1'b1;
    opcode = op;
    #2;
  endtask

  task automatic release_bus();
    @(negedge clk);
    opValid = 1'b0;
    opcode = 8'hEA;
    #2;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    bit undef;
    int len, cyc;
    bit [9:0] rd;
    string req;

    // R1 reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "irqHold in reset", irqHold, 0);
    chk("R1", "nopActive in reset", nopActive, 0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    chk("R1", "isDefined after reset", isDefined, 0);
    chk("R1", "nopDone after reset", nopDone, 0);
    chk("R1", "nopTotal after reset", nopTotal, 0);
    idle_check("R1");

    // full opcode sweep
    for (int op = 0; op < 256; op++) begin
      model(op, undef, len, cyc, rd, req);
      fetch(8'(op));
      chk("R6", $sformatf("isDefined op=%02h", op), isDefined, undef ? 0 : 1);
      chk(req, $sformatf("nopActive op=%02h", op), nopActive, undef ? 1 : 0);
      if (undef) begin
        chk("R7", $sformatf("cycIdx c1 op=%02h", op), cycIdx, 1);
        chk(req, $sformatf("nopTotal op=%02h", op), nopTotal, cyc);
        chk("R7", $sformatf("nopDone c1 op=%02h", op), nopDone, cyc == 1 ? 1 : 0);
        chk(req, $sformatf("pcStep c1 op=%02h", op), pcStep, cyc == 1 ? len : 0);
        chk("R10", $sformatf("cycRead c1 op=%02h", op), cycRead, 0);
      end
      release_bus();
      chk("R9", $sformatf("irqHold after op=%02h", op), irqHold, (undef && cyc == 1) ? 1 : 0);
      chk("R6", $sformatf("isDefined c2 op=%02h", op), isDefined, 0);
      for (int k = 2; k <= cyc; k++) begin
        if (k > 2) begin
          @(negedge clk);
          #2;
        end
        chk("R7", $sformatf("cycIdx c%0d op=%02h", k, op), cycIdx, k);
        chk("R7", $sformatf("nopTotal c%0d op=%02h", k, op), nopTotal, cyc);
        chk("R7", $sformatf("nopDone c%0d op=%02h", k, op), nopDone, k == cyc ? 1 : 0);
        chk(req, $sformatf("pcStep c%0d op=%02h", k, op), pcStep, k == cyc ? len : 0);
        chk(req, $sformatf("cycRead c%0d op=%02h", k, op), cycRead, rd[k]);
      end
      if (cyc >= 2) begin
        @(negedge clk);
        #2;
      end
      idle_check(req);
    end

    // R8 fetch strobes during a long no-operation
    fetch(8'h13);
    release_bus();
    chk("R9", "irqHold set before busy test", irqHold, 1);
    fetch(8'h5C);
    release_bus();
    fetch(8'h03);
    chk("R8", "cycIdx with ignored 03", cycIdx, 3);
    chk("R8", "isDefined with ignored 03", isDefined, 0);
    fetch(8'hA9);
    chk("R8", "cycIdx with ignored A9", cycIdx, 4);
    chk("R8", "isDefined with ignored A9", isDefined, 0);
    release_bus();
    chk("R8", "cycIdx after strobes", cycIdx, 5);
    chk("R8", "irqHold kept through ignored fetches", irqHold, 0);
    for (int k = 6; k <= 8; k++) begin
      @(negedge clk);
      #2;
    end
    chk("R8", "nopDone at cycle 8", nopDone, 1);
    chk("R5", "pcStep at cycle 8", pcStep, 3);
    @(negedge clk);
    #2;
    idle_check("R8");

    // R9 interrupt hold across runs, gaps and other opcodes
    fetch(8'h03);
    fetch(8'h13);
    chk("R9", "irqHold after first single", irqHold, 1);
    release_bus();
    chk("R9", "irqHold after back-to-back singles", irqHold, 1);
    repeat (3) @(negedge clk);
    #2;
    chk("R9", "irqHold kept over idle gap", irqHold, 1);
    fetch(8'hEA);
    release_bus();
    chk("R9", "irqHold cleared by defined", irqHold, 0);
    fetch(8'hFB);
    release_bus();
    chk("R9", "irqHold set by FB", irqHold, 1);
    fetch(8'h02);
    release_bus();
    chk("R9", "irqHold cleared by 2-cycle", irqHold, 0);
    @(negedge clk);
    #2;
    idle_check("R9");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule